// File: doc/BRIEF.md
# Interleaved Three-Phase PWM Generator

This block drives the gates of a three-phase interleaved synchronous buck stage. A master time base counts up from zero to a programmable period and marks each wrap with a one-clock sync pulse. Each phase has its own slave counter. On every sync pulse the slave counter reloads at a fixed fraction of the period, so the phase counters stay spaced one third of a period apart (120 degrees).

Each phase turns its counter and a buffered compare value into a raw high-side command. That command passes through a dead-band stage, which delays every turn-on by a fixed number of clocks. The result is a high-side and low-side pair that are never on at the same time. A new compare value written by the control loop takes effect only at the end of a phase's period, so it cannot shorten or stretch a pulse that is already running. Each phase also produces one converter start pulse per period at a programmable count. The loop uses this pulse to time its current or voltage sample.

Top module: `ilv_pwm3`

## Requirements
- R1: The master counter runs 0..`period_i` and wraps, so the period is `period_i`+1 clocks. `sync_o` is high for exactly one clock, during the clock in which the master count is 0; the first such clock comes `period_i`+1 clocks after reset release.
- R2: After the first sync, the counter of phase k (k = 0, 1, 2) equals (master count + floor(k·`period_i`/3)) mod (`period_i`+1). The phase counter reloads this relation on every sync pulse.
- R3: With an active compare A value `a` where DB_CYC < `a` < `period_i`, the high-side output `hs_o[k]` is high exactly while the phase count lies in DB_CYC+1..`a` (DB_CYC = 15).
- R4: The compare A input of a phase is copied to the active value only in the clock in which that phase's count equals `period_i`. A change made mid-period leaves the rest of that period unaffected.
- R5: The low-side output `ls_o[k]` is high while the phase count lies in `a`+1+DB_CYC..`period_i`, and also at count 0 (when `a`+1+DB_CYC ≤ `period_i`). `hs_o[k]` and `ls_o[k]` are never high together, and at least DB_CYC clocks with both low separate the end of one from the start of the other.
- R6: An active compare A of 0 keeps `hs_o[k]` low and `ls_o[k]` high. An active compare A at or above `period_i` keeps `hs_o[k]` high and `ls_o[k]` low.
- R7: `soc_o[k]` is a one-clock pulse, once per period. It is high in the clock after the phase count equals the phase's compare B value, which lands at count (b+1) mod (`period_i`+1). A compare B above `period_i` gives no pulse.
- R8: While `rst_ni` is low, every output (`sync_o`, `hs_o`, `ls_o`, `soc_o`) is low. This holds from the moment reset is asserted, even mid-period.
- R9: A compare A value in 1..DB_CYC gives a raw pulse shorter than the dead band, so `hs_o[k]` stays low for the whole period. `ls_o[k]` still follows R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Last count value of every counter |
| cmpa_i | input | N_PH*CNT_W | Compare A per phase (phase k at bits k*CNT_W), buffered |
| cmpb_i | input | N_PH*CNT_W | Compare B per phase, sets the start-pulse position |
| sync_o | output | 1 | One-clock pulse while the master count is 0 |
| hs_o | output | N_PH | High-side gate command per phase |
| ls_o | output | N_PH | Low-side gate command per phase |
| soc_o | output | N_PH | Converter start pulse per phase |

## Verification
The assertions check on every cycle the properties that hold whatever values are programmed. No pair overlaps, and the dead gap before each turn-on lasts at least DB_CYC clocks. Sync and start pulses last one clock. A phase count never exceeds the period, and the active compare value changes only at a phase's period count. The bench scenarios are needed for the rest, because those outcomes depend on the programmed values: the exact 120-degree spacing, the pulse edge positions for each compare value, the saturated 0 and full-on cases, swallowed short pulses, start pulses against compare B (including values beyond the period), and the deferral of a compare change that arrives mid-period.

// File: rtl/ilv_pwm_pkg.sv
package ilv_pwm_pkg;

  // slave reload offset: floor(idx * prd / nph)
  function automatic logic [31:0] phase_offset(input logic [31:0] prd,
                                               input int unsigned idx,
                                               input int unsigned nph);
    return (prd * idx) / nph;
  endfunction

endpackage

// File: rtl/ilv_master_tb.sv
module ilv_master_tb #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic             sync_o
);

  logic [CNT_W-1:0] cnt_q;

  // sync_o is registered alongside the wrap, so it is high while cnt_q == 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sync_o <= 1'b0;
    end else if (cnt_q >= period_i) begin
      cnt_q  <= '0;
      sync_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      sync_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ilv_phase_tb.sv
module ilv_phase_tb #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] cmpa_i,
  input  logic [CNT_W-1:0] cmpb_i,
  output logic             raw_o,
  output logic             soc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmpa_act_o
);

  logic [CNT_W-1:0] cnt_q, act_q;
  logic             armed_q, hit;

  // sync arrives while master is 0, so load offset+1 to track master+offset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (sync_i)           cnt_q <= offset_i + 1'b1;
    else if (cnt_q >= period_i) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 act_q <= '0;
    else if (cnt_q == period_i)  act_q <= cmpa_i;
  end

  assign raw_o = (act_q >= period_i) || (cnt_q < act_q);

  assign hit = armed_q && (cnt_q == cmpb_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      soc_o   <= 1'b0;
    end else begin
      soc_o <= hit;
      if (cnt_q == period_i) armed_q <= 1'b1;
      else if (hit)          armed_q <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign cmpa_act_o = act_q;

endmodule

// File: rtl/ilv_deadband.sv
module ilv_deadband #(
  parameter int DB_CYC = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic hs_o,
  output logic ls_o
);

  localparam int DW = (DB_CYC < 1) ? 1 : $clog2(DB_CYC + 1);
  localparam logic [DW-1:0] DB_V = DW'(DB_CYC);

  logic          raw_q;
  logic [DW-1:0] dly_q;
  logic          settled;

  // dly_q counts clocks since the last raw edge, saturating at DB_V
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      dly_q <= '0;
    end else begin
      raw_q <= raw_i;
      if (raw_i != raw_q)  dly_q <= '0;
      else if (dly_q != DB_V) dly_q <= dly_q + 1'b1;
    end
  end

  assign settled = (dly_q == DB_V);
  assign hs_o    = raw_q & settled;
  assign ls_o    = ~raw_q & settled;

endmodule

// File: rtl/ilv_pwm3.sv
module ilv_pwm3
  import ilv_pwm_pkg::*;
#(
  parameter int N_PH   = 3,
  parameter int CNT_W  = 16,
  parameter int DB_CYC = 15
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CNT_W-1:0]      period_i,
  input  logic [N_PH*CNT_W-1:0] cmpa_i,
  input  logic [N_PH*CNT_W-1:0] cmpb_i,
  output logic                  sync_o,
  output logic [N_PH-1:0]       hs_o,
  output logic [N_PH-1:0]       ls_o,
  output logic [N_PH-1:0]       soc_o
);

  logic                  sync;
  logic [N_PH-1:0]       raw;
  logic [N_PH*CNT_W-1:0] slv_cnt;
  logic [N_PH*CNT_W-1:0] cmpa_act;

  ilv_master_tb #(.CNT_W(CNT_W)) u_master (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .period_i(period_i),
    .sync_o  (sync)
  );

  for (genvar k = 0; k < N_PH; k++) begin : g_ph
    logic [CNT_W-1:0] offset;

    assign offset = CNT_W'(phase_offset(32'(period_i), k, N_PH));

    ilv_phase_tb #(.CNT_W(CNT_W)) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .period_i  (period_i),
      .offset_i  (offset),
      .sync_i    (sync),
      .cmpa_i    (cmpa_i[k*CNT_W +: CNT_W]),
      .cmpb_i    (cmpb_i[k*CNT_W +: CNT_W]),
      .raw_o     (raw[k]),
      .soc_o     (soc_o[k]),
      .cnt_o     (slv_cnt[k*CNT_W +: CNT_W]),
      .cmpa_act_o(cmpa_act[k*CNT_W +: CNT_W])
    );

    ilv_deadband #(.DB_CYC(DB_CYC)) u_db (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[k]),
      .hs_o  (hs_o[k]),
      .ls_o  (ls_o[k])
    );
  end

  assign sync_o = sync;

endmodule

// File: rtl/ilv_pwm3_chk.sv
module ilv_pwm3_chk #(
  parameter int N_PH   = 3,
  parameter int CNT_W  = 16,
  parameter int DB_CYC = 15
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [CNT_W-1:0]      period_i,
  input logic                  sync_o,
  input logic [N_PH-1:0]       hs_o,
  input logic [N_PH-1:0]       ls_o,
  input logic [N_PH-1:0]       soc_o,
  input logic [N_PH*CNT_W-1:0] slv_cnt,
  input logic [N_PH*CNT_W-1:0] cmpa_act
);

  p_sync_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o) else $error("sync pulse longer than one clock");

  for (genvar k = 0; k < N_PH; k++) begin : g_chk
    int unsigned gap_q;

    // clocks with both outputs of the pair low, saturating
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  gap_q <= 0;
      else if (hs_o[k] || ls_o[k])  gap_q <= 0;
      else if (gap_q < DB_CYC)      gap_q <= gap_q + 1;
    end

    p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_o[k] && ls_o[k])) else $error("pair overlap");

    p_ls_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ls_o[k]) |-> gap_q >= DB_CYC) else $error("low-side dead band short");

    p_hs_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_o[k]) |-> gap_q >= DB_CYC) else $error("high-side dead band short");

    p_soc_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soc_o[k] |=> !soc_o[k]) else $error("start pulse longer than one clock");

    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slv_cnt[k*CNT_W +: CNT_W] <= period_i) else $error("phase count beyond period");

    p_cmpa_shadow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cmpa_act[k*CNT_W +: CNT_W]) |->
        $past(slv_cnt[k*CNT_W +: CNT_W]) == $past(period_i))
      else $error("active compare changed off the period count");
  end

endmodule

bind ilv_pwm3 ilv_pwm3_chk #(.N_PH(N_PH), .CNT_W(CNT_W), .DB_CYC(DB_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .period_i(period_i),
  .sync_o  (sync_o),
  .hs_o    (hs_o),
  .ls_o    (ls_o),
  .soc_o   (soc_o),
  .slv_cnt (slv_cnt),
  .cmpa_act(cmpa_act)
);

// File: tb/sim_ilv_pwm3.sv
module sim_ilv_pwm3;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int W  = 16;
  localparam int DB = 15;
  localparam int P  = 299;

  typedef struct {
    int        stamp;
    logic [2:0] mask;
    logic [2:0] hs;
    logic [2:0] ls;
    logic [2:0] soc;
    logic       sync;
    bit         full;
    string      tag;
  } exp_item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [W-1:0]    period = W'(P);
  logic [NP*W-1:0] cmpa = '0;
  logic [NP*W-1:0] cmpb = '0;
  logic            sync;
  logic [NP-1:0]   hs, ls, soc;

  int        n_chk = 0;
  int        n_fail = 0;
  int        ncyc = 0;
  bit        done = 1'b0;
  int        a_v[NP];
  int        b_v[NP];
  exp_item_t sb_q[$];
  exp_item_t it_m;

  ilv_pwm3 #(.N_PH(NP), .CNT_W(W), .DB_CYC(DB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period),
    .cmpa_i(cmpa), .cmpb_i(cmpb),
    .sync_o(sync), .hs_o(hs), .ls_o(ls), .soc_o(soc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;
  end

  function automatic int ph_cnt(int n, int k);
    return (n + (k * P) / NP) % (P + 1);
  endfunction

  function automatic logic exp_hs(int c, int a);
    if (a >= P) return 1'b1;
    return (c >= DB + 1) && (c <= a);
  endfunction

  function automatic logic exp_ls(int c, int a);
    if (a >= P) return 1'b0;
    if (a == 0) return 1'b1;
    return (c >= a + 1 + DB) || (c == 0 && a + 1 + DB <= P);
  endfunction

  function automatic logic exp_soc(int c, int b);
    if (b > P) return 1'b0;
    return c == ((b + 1) % (P + 1));
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, expv, ncyc);
    end
  endtask

  // monitor: compare queued expectations at their stamped cycle
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].stamp <= ncyc) begin
        it_m = sb_q.pop_front();
        if (it_m.stamp < ncyc) begin
          chk(1'b0, {it_m.tag, " missed"}, it_m.stamp, ncyc);
        end else begin
          chk((hs & it_m.mask) == (it_m.hs & it_m.mask), {it_m.tag, " hs"},
              int'(hs & it_m.mask), int'(it_m.hs & it_m.mask));
          chk((ls & it_m.mask) == (it_m.ls & it_m.mask), {it_m.tag, " ls"},
              int'(ls & it_m.mask), int'(it_m.ls & it_m.mask));
          if (it_m.full) begin
            chk(soc == it_m.soc, {it_m.tag, " soc"}, int'(soc), int'(it_m.soc));
            chk(sync == it_m.sync, {it_m.tag, " sync"}, int'(sync), int'(it_m.sync));
          end
        end
      end
    end
  end

  task automatic set_cmp(int a0, int a1, int a2, int b0, int b1, int b2);
    a_v[0] = a0; a_v[1] = a1; a_v[2] = a2;
    b_v[0] = b0; b_v[1] = b1; b_v[2] = b2;
    for (int k = 0; k < NP; k++) begin
      cmpa[k*W +: W] = W'(a_v[k]);
      cmpb[k*W +: W] = W'(b_v[k]);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one full period of expectations starting next cycle
  task automatic push_period(string tag);
    int s = ncyc + 1;
    for (int i = 0; i <= P; i++) begin
      exp_item_t e;
      e.stamp = s + i;
      e.mask  = 3'b111;
      e.full  = 1'b1;
      e.tag   = tag;
      e.sync  = ((s + i) % (P + 1)) == 0;
      for (int k = 0; k < NP; k++) begin
        int c = ph_cnt(s + i, k);
        e.hs[k]  = exp_hs(c, a_v[k]);
        e.ls[k]  = exp_ls(c, a_v[k]);
        e.soc[k] = exp_soc(c, b_v[k]);
      end
      sb_q.push_back(e);
    end
  endtask

  task automatic push_point(int stamp, int k, logic h, logic l, string tag);
    exp_item_t e;
    e.stamp = stamp; e.mask = 3'b000; e.mask[k] = 1'b1;
    e.hs = '0; e.ls = '0; e.hs[k] = h; e.ls[k] = l;
    e.soc = '0; e.sync = 1'b0; e.full = 1'b0; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic run_window(string tag);
    wait_cyc(2 * (P + 1));
    push_period(tag);
    wait_cyc(P + 3);
  endtask

  initial begin
    int n0;
    set_cmp(150, 150, 150, 10, 20, 30);
    wait_cyc(3);
    // R8: reset state
    chk({sync, hs, ls, soc} == '0, "R8 reset outputs", int'({sync, hs, ls, soc}), 0);
    rst_n = 1'b1;

    run_window("R1 R2 R3 R5 R7 mid duty");

    set_cmp(60, 240, 100, 0, P, 350);
    run_window("R2 R3 R5 R7 mixed duty, edge compare B");

    set_cmp(0, 400, 10, 5, 5, 5);
    run_window("R6 R9 saturated and short");

    // R4: mid-period change on phase 0 is deferred to the next period
    set_cmp(150, 150, 150, 10, 20, 30);
    wait_cyc(2 * (P + 1));
    while (ph_cnt(ncyc, 0) != 30) wait_cyc(1);
    cmpa[0 +: W] = W'(60);
    n0 = ncyc;
    push_point(n0 + 40, 0, 1'b1, 1'b0, "R4 old compare held");
    push_point(n0 + 40 + P + 1, 0, 1'b0, 1'b0, "R4 new compare applied hs");
    push_point(n0 + 50 + P + 1, 0, 1'b0, 1'b1, "R4 new compare applied ls");
    wait_cyc(2 * (P + 1));
    a_v[0] = 60;
    run_window("R3 R5 after update");

    // R8: asynchronous reset mid-run
    set_cmp(400, 400, 400, 10, 20, 30);
    wait_cyc(2 * (P + 1));
    chk(hs == 3'b111, "R6 full on before reset", int'(hs), 7);
    rst_n = 1'b0;
    #1;
    chk({sync, hs, ls, soc} == '0, "R8 reset mid-run", int'({sync, hs, ls, soc}), 0);
    chk(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule